// File: doc/BRIEF.md
# Packet Buffer Pointer and Data Window

This block gives a host byte-wide access to a packet buffer made of four 2 KB pages. The host loads a 16-bit pointer as two independent bytes. Two flag bits inside the pointer control the access. One picks which page is used: the page at the head of the receive queue, or the page named by the packet-number register. The other chooses how the byte address is formed: auto-increment, or an explicit byte lane. The low eleven pointer bits give the byte offset inside the selected page.

Accesses go through a four-byte data window. With auto-increment off, the window lane (0 to 3) is added to the offset and the pointer does not move. With auto-increment on, every window access uses the current offset and then advances it by one. The block drives an external synchronous single-port RAM and returns read data one cycle after the request. Both page numbers arrive as inputs from the allocation logic.

Top module: `pkt_data_port`

## Requirements
- R1: After reset the pointer is zero, `rdValid` is low, and a read of either pointer byte returns 0x00.
- R2: A write to register address 0 replaces pointer bits 7:0 only. A write to address 1 replaces bits 15:8 only.
- R3: A read of address 1 returns pointer bits 15:8 ANDed with 0xF7, so stored bit 11 reads as 0. A read of address 0 returns bits 7:0 unchanged.
- R4: On a window access (register addresses 4 to 7), `ramAddr[12:11]` is `rxHeadPage` when pointer bit 15 is 1 and `txPage` when it is 0.
- R5: With pointer bit 14 clear, `ramAddr[10:0]` equals pointer bits 10:0 plus the lane (register address minus 4), modulo 2048, and the pointer is left unchanged.
- R6: With pointer bit 14 set, `ramAddr[10:0]` equals pointer bits 10:0. After the access those bits have advanced by one, wrapping from 2047 to 0, and pointer bits 15:11 are unchanged.
- R7: A window write asserts `ramEn` and `ramWe` in the same cycle with `ramWdata` equal to `regWdata`. A window read asserts `ramEn` with `ramWe` low.
- R8: Every read request is answered by `rdValid` high for exactly the next cycle. For a window read, `rdData` is the RAM byte at the address formed in the request cycle.
- R9: Register addresses 2 and 3 read as 0x00, and writes to them change neither the pointer nor the RAM.
- R10: When `regWrEn` and `regRdEn` are both high, only the write is carried out and no read response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register byte write strobe |
| regRdEn | input | 1 | Register byte read strobe |
| regAddr | input | 3 | 0/1 pointer low/high, 4..7 data window lanes |
| regWdata | input | 8 | Write byte |
| rdValid | output | 1 | Read response valid |
| rdData | output | 8 | Read response byte |
| txPage | input | 2 | Page held in the packet-number register |
| rxHeadPage | input | 2 | Page at the head of the receive queue |
| ramEn | output | 1 | RAM access enable |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 13 | RAM byte address {page, offset} |
| ramWdata | output | 8 | RAM write byte |
| ramRdata | input | 8 | RAM read byte, one cycle after the request |

## Verification
The hardest case to reach from the ports is the offset wrap. In auto-increment mode the wrap happens when the offset passes 2047 while the upper flag and page bits must stay as they were. In lane mode the sum of offset and lane crosses the page end. The stimulus writes the pointer high byte with both flags and bit 11 set and the low byte to 0xFE. It then makes several window accesses in a row, so the increment crosses 2047 and the pointer read-back also shows the hidden bit 11. Lane mode is tested the same way, by writing offset 0x7FE and accessing lane 3.

// File: rtl/pkt_data_port_pkg.sv
package pkt_data_port_pkg;

  typedef enum logic [1:0] {
    SEL_ZERO   = 2'd0,
    SEL_PTR_LO = 2'd1,
    SEL_PTR_HI = 2'd2,
    SEL_RAM    = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic    ptrLoWr;
    logic    ptrHiWr;
    logic    winAcc;
    logic    winWr;
    logic [1:0] lane;
    logic    rdReq;
    rd_sel_e rdSel;
  } strobe_t;

  localparam int PTR_W      = 16;
  localparam int RX_FLAG    = 15;
  localparam int INC_FLAG   = 14;
  localparam logic [7:0] HI_READ_MASK = 8'hF7;

endpackage

// File: rtl/pkt_data_port_ctrl.sv
module pkt_data_port_ctrl
  import pkt_data_port_pkg::*;
(
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regAddr,
  output strobe_t    strobe
);

  localparam logic [2:0] ADDR_PTR_LO = 3'd0;
  localparam logic [2:0] ADDR_PTR_HI = 3'd1;

  logic isWin;
  logic doRead;

  assign isWin  = regAddr[2];
  assign doRead = regRdEn && !regWrEn;

  always_comb begin
    strobe         = '0;
    strobe.lane    = regAddr[1:0];
    strobe.rdSel   = SEL_ZERO;
    strobe.rdReq   = doRead;
    if (regWrEn) begin
      strobe.ptrLoWr = (regAddr == ADDR_PTR_LO);
      strobe.ptrHiWr = (regAddr == ADDR_PTR_HI);
      strobe.winAcc  = isWin;
      strobe.winWr   = isWin;
    end else if (regRdEn) begin
      strobe.winAcc = isWin;
      if (isWin)                       strobe.rdSel = SEL_RAM;
      else if (regAddr == ADDR_PTR_LO) strobe.rdSel = SEL_PTR_LO;
      else if (regAddr == ADDR_PTR_HI) strobe.rdSel = SEL_PTR_HI;
      else                             strobe.rdSel = SEL_ZERO;
    end
  end

endmodule

// File: rtl/pkt_data_port_dp.sv
module pkt_data_port_dp
  import pkt_data_port_pkg::*;
#(
  parameter int PAGE_COUNT = 4,
  parameter int PAGE_BYTES = 2048,
  localparam int OFS_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = $clog2(PAGE_COUNT),
  localparam int RAM_AW = OFS_W + PG_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [7:0]        regWdata,
  input  logic [PG_W-1:0]   txPage,
  input  logic [PG_W-1:0]   rxHeadPage,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output logic              ramEn,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);

  logic [PTR_W-1:0] ptrQ;
  logic [OFS_W-1:0] curOfs;
  logic [OFS_W-1:0] accOfs;
  logic [PG_W-1:0]  accPage;
  logic             autoInc;
  logic [7:0]       holdQ;
  logic             selRamQ;
  logic [7:0]       ptrLoByte;
  logic [7:0]       ptrHiByte;

  assign curOfs  = ptrQ[OFS_W-1:0];
  assign autoInc = ptrQ[INC_FLAG];
  assign accPage = ptrQ[RX_FLAG] ? rxHeadPage : txPage;
  assign accOfs  = autoInc ? curOfs : curOfs + OFS_W'(strobe.lane);

  assign ramEn    = strobe.winAcc;
  assign ramWe    = strobe.winAcc && strobe.winWr;
  assign ramAddr  = {accPage, accOfs};
  assign ramWdata = regWdata;

  assign ptrLoByte = ptrQ[7:0];
  assign ptrHiByte = ptrQ[15:8] & HI_READ_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strobe.ptrLoWr) begin
      ptrQ[7:0] <= regWdata;
    end else if (strobe.ptrHiWr) begin
      ptrQ[15:8] <= regWdata;
    end else if (strobe.winAcc && autoInc) begin
      ptrQ[OFS_W-1:0] <= curOfs + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      selRamQ <= 1'b0;
      holdQ   <= '0;
    end else begin
      rdValid <= strobe.rdReq;
      selRamQ <= strobe.rdReq && (strobe.rdSel == SEL_RAM);
      case (strobe.rdSel)
        SEL_PTR_LO: holdQ <= ptrLoByte;
        SEL_PTR_HI: holdQ <= ptrHiByte;
        default:    holdQ <= '0;
      endcase
    end
  end

  assign rdData = selRamQ ? ramRdata : holdQ;

endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port
  import pkt_data_port_pkg::*;
#(
  parameter int PAGE_COUNT = 4,
  parameter int PAGE_BYTES = 2048,
  localparam int OFS_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = $clog2(PAGE_COUNT),
  localparam int RAM_AW = OFS_W + PG_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic              rdValid,
  output logic [7:0]        rdData,
  input  logic [PG_W-1:0]   txPage,
  input  logic [PG_W-1:0]   rxHeadPage,
  output logic              ramEn,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);

  strobe_t strobe;

  pkt_data_port_ctrl uCtrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  pkt_data_port_dp #(
    .PAGE_COUNT (PAGE_COUNT),
    .PAGE_BYTES (PAGE_BYTES)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regWdata   (regWdata),
    .txPage     (txPage),
    .rxHeadPage (rxHeadPage),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .ramEn      (ramEn),
    .ramWe      (ramWe),
    .ramAddr    (ramAddr),
    .ramWdata   (ramWdata),
    .ramRdata   (ramRdata)
  );

endmodule

// File: rtl/pkt_data_port_chk.sv
module pkt_data_port_chk #(
  parameter int PG_W   = 2,
  parameter int OFS_W  = 11,
  parameter int RAM_AW = 13
)(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [2:0]        regAddr,
  input logic [7:0]        regWdata,
  input logic              rdValid,
  input logic [7:0]        rdData,
  input logic [PG_W-1:0]   txPage,
  input logic [PG_W-1:0]   rxHeadPage,
  input logic              ramEn,
  input logic              ramWe,
  input logic [RAM_AW-1:0] ramAddr,
  input logic [7:0]        ramWdata,
  input logic [15:0]       ptr
);

  AST_PAGE_PICK: assert property (@(posedge clk) disable iff (!rstN)
    ramEn |-> ramAddr[RAM_AW-1:OFS_W] == (ptr[15] ? rxHeadPage : txPage)); // R4

  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ramEn && !ptr[14]) |=> $stable(ptr)); // R5

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ramEn && ptr[14]) |=> (ptr[OFS_W-1:0] == $past(ptr[OFS_W-1:0]) + 1'b1)
                          && (ptr[15:OFS_W] == $past(ptr[15:OFS_W]))); // R6

  AST_WE_FROM_WR: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (regWrEn && ramEn && ramWdata == regWdata)); // R7

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn) |=> rdValid); // R8

  AST_NO_RESP_ON_WR: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !rdValid); // R10

  AST_HI_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn && regAddr == 3'd1) |=> (rdData[3] == 1'b0)); // R3

endmodule

bind pkt_data_port pkt_data_port_chk #(
  .PG_W   (PG_W),
  .OFS_W  (OFS_W),
  .RAM_AW (RAM_AW)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regRdEn    (regRdEn),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .rdValid    (rdValid),
  .rdData     (rdData),
  .txPage     (txPage),
  .rxHeadPage (rxHeadPage),
  .ramEn      (ramEn),
  .ramWe      (ramWe),
  .ramAddr    (ramAddr),
  .ramWdata   (ramWdata),
  .ptr        (uDp.ptrQ)
);

// File: tb/test_pkt_data_port.sv
module test_pkt_data_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic        rdValid;
  logic [7:0]  rdData;
  logic [1:0]  txPage = 2'd1;
  logic [1:0]  rxHeadPage = 2'd2;
  logic        ramEn;
  logic        ramWe;
  logic [12:0] ramAddr;
  logic [7:0]  ramWdata;
  logic [7:0]  ramRdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] mPtr;
  logic [7:0]  mem [int];
  logic [7:0]  expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  pkt_data_port i_pkt_data_port (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .rdValid(rdValid),
    .rdData(rdData), .txPage(txPage), .rxHeadPage(rxHeadPage),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  // synchronous RAM model, one-cycle read latency
  always @(posedge clk) begin
    if (ramEn) begin
      if (ramWe) mem[int'(ramAddr)] = ramWdata;
      else ramRdata <= mem.exists(int'(ramAddr)) ? mem[int'(ramAddr)] : 8'h00;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a response appears
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) check("R8 unexpected rdValid", 1, 0);
      else check(tagQ.pop_front(), {24'd0, rdData}, {24'd0, expQ.pop_front()});
    end
  end

  function automatic logic [12:0] expAddr(input int lane);
    logic [10:0] o;
    o = mPtr[14] ? mPtr[10:0] : mPtr[10:0] + 11'(lane);
    return {(mPtr[15] ? rxHeadPage : txPage), o};
  endfunction

  task automatic idle();
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0;
  endtask

  task automatic wrPtr(input bit hi, input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regRdEn = 1'b0; regAddr = hi ? 3'd1 : 3'd0; regWdata = v;
    if (hi) mPtr[15:8] = v; else mPtr[7:0] = v;
    idle();
  endtask

  task automatic rdPtr(input bit hi, input string tag);
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b1; regAddr = hi ? 3'd1 : 3'd0;
    expQ.push_back(hi ? (mPtr[15:8] & 8'hF7) : mPtr[7:0]);
    tagQ.push_back(tag);
    idle();
  endtask

  task automatic winAcc(input bit wr, input int lane, input logic [7:0] v, input string tag);
    logic [12:0] a;
    @(negedge clk);
    regWrEn = wr; regRdEn = !wr; regAddr = 3'(4 + lane); regWdata = v;
    a = expAddr(lane);
    #1;
    check({tag, " addr"}, {19'd0, ramAddr}, {19'd0, a});
    check({tag, " R7 en/we"}, {30'd0, ramEn, ramWe}, {30'd0, 1'b1, wr});
    if (!wr) begin
      expQ.push_back(mem.exists(int'(a)) ? mem[int'(a)] : 8'h00);
      tagQ.push_back({tag, " R8 data"});
    end else begin
      check({tag, " R7 wdata"}, {24'd0, ramWdata}, {24'd0, v});
    end
    if (mPtr[14]) mPtr[10:0] = mPtr[10:0] + 11'd1;
    idle();
  endtask

  initial begin
    mPtr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 rdValid after reset", {31'd0, rdValid}, 0);
    rdPtr(0, "R1 ptr lo reset");
    rdPtr(1, "R1 ptr hi reset");

    // R2 independent byte writes
    wrPtr(0, 8'h5A);
    wrPtr(1, 8'h03);
    rdPtr(0, "R2 ptr lo");
    rdPtr(1, "R2 ptr hi");
    wrPtr(0, 8'h10);
    rdPtr(1, "R2 hi kept after lo write");

    // R3 bit 11 hidden on read
    wrPtr(1, 8'h0F);
    rdPtr(1, "R3 hi masked");
    rdPtr(0, "R3 lo unmasked");

    // R5 lane mode, tx page (bit15 clear), R4
    wrPtr(1, 8'h00); wrPtr(0, 8'h20);
    for (int l = 0; l < 4; l++) winAcc(1, l, 8'hA0 + 8'(l), "R5 R4 lane wr");
    for (int l = 0; l < 4; l++) winAcc(0, l, 8'h00, "R5 lane rd");
    rdPtr(0, "R5 pointer unchanged");
    // lane wrap at page end
    wrPtr(1, 8'h07); wrPtr(0, 8'hFE);
    winAcc(1, 3, 8'h77, "R5 lane wrap wr");
    wrPtr(1, 8'h00); wrPtr(0, 8'h01);
    winAcc(0, 0, 8'h00, "R5 lane wrap rd");

    // R6 auto-increment with rx page (bit15) and bit11 set, crossing 2047
    wrPtr(1, 8'hCF); wrPtr(0, 8'hFE);
    winAcc(1, 2, 8'h31, "R6 R4 inc wr");
    winAcc(1, 0, 8'h32, "R6 inc wr");
    winAcc(1, 1, 8'h33, "R6 inc wr wrap");
    rdPtr(0, "R6 lo after wrap");
    rdPtr(1, "R6 hi kept");
    wrPtr(1, 8'hC7); wrPtr(0, 8'hFE);
    for (int k = 0; k < 3; k++) winAcc(0, k, 8'h00, "R6 inc rd");
    rxHeadPage = 2'd3;
    winAcc(0, 0, 8'h00, "R4 rx page change");

    // R9 unmapped addresses
    @(negedge clk); regWrEn = 1'b1; regAddr = 3'd2; regWdata = 8'hFF;
    #1 check("R9 no ram on unmapped wr", {31'd0, ramEn}, 0);
    idle();
    @(negedge clk); regWrEn = 1'b1; regAddr = 3'd3; regWdata = 8'hFF; idle();
    @(negedge clk); regRdEn = 1'b1; regAddr = 3'd2;
    expQ.push_back(8'h00); tagQ.push_back("R9 unmapped read");
    idle();
    rdPtr(0, "R9 ptr lo unchanged");
    rdPtr(1, "R9 ptr hi unchanged");

    // R10 write wins over read
    @(negedge clk); regWrEn = 1'b1; regRdEn = 1'b1; regAddr = 3'd0; regWdata = 8'h44;
    mPtr[7:0] = 8'h44;
    idle();
    #1 check("R10 no response", {31'd0, rdValid}, 0);
    rdPtr(0, "R10 write applied");

    repeat (4) @(negedge clk);
    check("R8 all responses seen", expQ.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule